// File: doc/BRIEF.md
# Binary-Field Trinomial Hash Accumulator

This block compresses a fixed-length message into a polynomial over GF(2^64) and reduces it modulo a sparse trinomial of degree DEG. The message arrives as NUM_BLOCKS equal-sized blocks on a valid/ready input. Each block becomes one 64-bit base-field element. The running polynomial is multiplied by (t + element) once per block. When the final block has been absorbed, the DEG coefficients of the result appear on a wide output for a single cycle.

A single bit-serial GF(2^64) multiplier does all the base-field products. It works through the coefficients one at a time, at one multiplier bit per clock. The input therefore stalls for a fixed number of cycles after each block except the first. This fits designs that need a compact, deterministic compression step and can accept a few hundred cycles per block.

Top module: `fsh_accum`

## Requirements
- R1: After reset, outValid is 0, inReady is 1 and outCoeffs is all zero.
- R2: Block number n (counted from 1 within a message) maps to the element whose top IDX_BYTES*8 bits hold n, whose next BLK_BYTES*8 bits hold the block data, and whose remaining low bits are zero.
- R3: The first block of a message sets the accumulator to the constant polynomial equal to its element, with no multiplication and no input stall.
- R4: For block numbers 2 through DEG-1, the accumulator is multiplied by (t + element) and no reduction is applied.
- R5: For block numbers DEG through NUM_BLOCKS, the product is reduced modulo t^DEG + t^TAP + 1: the coefficient that lands on t^DEG is XORed into coefficients TAP and 0 and then dropped.
- R6: Base-field multiplication is a carry-less 64x64 product reduced modulo x^64 + x^4 + x^3 + x + 1, and base-field addition is XOR.
- R7: A block is taken only on a cycle where inValid and inReady are both 1. After every block other than the first, inReady stays 0 for exactly 64*DEG+1 cycles.
- R8: After the last block is taken, outValid rises 64*DEG+1 cycles after the acceptance edge and stays high for exactly one cycle. Coefficient j of the result sits in outCoeffs bits [64j+63:64j].
- R9: After the output cycle, the accumulator is cleared. Identical messages sent back to back give identical results.
- R10: Input activity during cycles where inReady is 0 has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Block offered |
| inData | input | BLK_BYTES*8 | Message block |
| inReady | output | 1 | Block can be taken this cycle |
| outValid | output | 1 | One-cycle result strobe |
| outCoeffs | output | DEG*64 | Result coefficients, coefficient 0 lowest |

## Verification
Most internal state reaches the ports only through the final coefficients, one message later. A wrong tap position, a wrongly skipped or applied reduction, a bad index prefix or a faulty base-field product therefore appears as a coefficient mismatch at the end of that message, about NUM_BLOCKS*(64*DEG+2) cycles after it starts. A control fault shows up at once in the stall length after each block or in the position and width of the output pulse. A failure to clear shows as nonzero outputs in the cycle after the pulse and as differing results for repeated messages.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  localparam int WORD = 64;
  // low terms of the base polynomial x^64 + x^4 + x^3 + x + 1
  localparam logic [WORD-1:0] BASE_POLY_LOW = 64'h1B;

  typedef struct packed {
    logic loadFirst;  // first block: accumulator takes the element directly
    logic capture;    // later block: latch element and top coefficient
    logic reduce;     // block number has reached DEG
    logic mulStep;    // advance the serial multiplier one bit
    logic mulLast;    // final bit: write the coefficient
    logic fold;       // fold the saved top coefficient into the taps
    logic clear;      // wipe the accumulator after output
  } fshStrobe_t;

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_FOLD, S_EMIT} fshState_t;

endpackage

// File: rtl/fsh_gf_mul_serial.sv
module fsh_gf_mul_serial
  import fsh_pkg::*;
#(
  parameter logic [WORD-1:0] POLY_LOW = BASE_POLY_LOW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            step,
  input  logic [WORD-1:0] mcand,
  input  logic            bitIn,
  output logic [WORD-1:0] prodNext
);

  logic [WORD-1:0] prod;
  logic [WORD-1:0] shifted;

  // MSB-first multiplier scan: double the partial product, then add
  always_comb begin
    shifted  = {prod[WORD-2:0], 1'b0} ^ (prod[WORD-1] ? POLY_LOW : '0);
    prodNext = shifted ^ (bitIn ? mcand : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     prod <= '0;
    else if (clear) prod <= '0;
    else if (step)  prod <= prodNext;
  end

endmodule

// File: rtl/fsh_control.sv
module fsh_control
  import fsh_pkg::*;
#(
  parameter int DEG        = 5,
  parameter int NUM_BLOCKS = 16,
  parameter int CNT_W      = $clog2(NUM_BLOCKS + 1),
  parameter int COEF_W     = $clog2(DEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  output logic              outValid,
  output fshStrobe_t        st,
  output logic [CNT_W-1:0]  blkIdx,
  output logic [COEF_W-1:0] coefIdx,
  output logic [5:0]        bitIdx
);

  localparam logic [CNT_W-1:0]  LAST_BLK    = CNT_W'(NUM_BLOCKS);
  localparam logic [CNT_W-1:0]  REDUCE_FROM = CNT_W'(DEG - 1);
  localparam logic [COEF_W-1:0] TOP_COEF    = COEF_W'(DEG - 1);

  fshState_t         state;
  logic [CNT_W-1:0]  blkCnt;
  logic [COEF_W-1:0] coefCnt;
  logic [5:0]        bitCnt;
  logic              accept;

  assign inReady  = (state == S_IDLE);
  assign outValid = (state == S_EMIT);
  assign accept   = inValid && inReady;
  assign blkIdx   = blkCnt + CNT_W'(1);
  assign coefIdx  = coefCnt;
  assign bitIdx   = bitCnt;

  always_comb begin
    st           = '0;
    st.loadFirst = accept && (blkCnt == '0);
    st.capture   = accept && (blkCnt != '0);
    st.reduce    = (blkCnt >= REDUCE_FROM);
    st.mulStep   = (state == S_MUL);
    st.mulLast   = (state == S_MUL) && (bitCnt == 6'd63);
    st.fold      = (state == S_FOLD);
    st.clear     = (state == S_EMIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      blkCnt  <= '0;
      coefCnt <= '0;
      bitCnt  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          blkCnt <= blkCnt + CNT_W'(1);
          if (blkCnt == '0) begin
            if (blkIdx == LAST_BLK) state <= S_EMIT;
          end else begin
            state   <= S_MUL;
            coefCnt <= TOP_COEF;
            bitCnt  <= '0;
          end
        end
        S_MUL: begin
          bitCnt <= bitCnt + 6'd1;
          if (bitCnt == 6'd63) begin
            if (coefCnt == '0) state <= S_FOLD;
            else coefCnt <= coefCnt - COEF_W'(1);
          end
        end
        S_FOLD: state <= (blkCnt == LAST_BLK) ? S_EMIT : S_IDLE;
        S_EMIT: begin
          blkCnt <= '0;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_STALL_AFTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    st.capture |=> !inReady); // R7
  AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |=> !outValid); // R8
  AST_NO_READY_ON_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !inReady); // R7
  AST_BLOCK_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    blkCnt <= LAST_BLK); // R8

endmodule

// File: rtl/fsh_datapath.sv
module fsh_datapath
  import fsh_pkg::*;
#(
  parameter int DEG       = 5,
  parameter int TAP       = 2,
  parameter int IDX_BYTES = 1,
  parameter int BLK_BYTES = 4,
  parameter int CNT_W     = 5,
  parameter int COEF_W    = $clog2(DEG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  fshStrobe_t             st,
  input  logic [CNT_W-1:0]       blkIdx,
  input  logic [COEF_W-1:0]      coefIdx,
  input  logic [5:0]             bitIdx,
  input  logic [BLK_BYTES*8-1:0] inData,
  output logic [DEG*WORD-1:0]    accFlat
);

  localparam int IDX_W  = IDX_BYTES * 8;
  localparam int DATA_W = BLK_BYTES * 8;
  localparam int PAD_W  = WORD - IDX_W - DATA_W;

  logic [WORD-1:0]   acc [DEG];
  logic [WORD-1:0]   alphaIn;
  logic [WORD-1:0]   alphaReg;
  logic [WORD-1:0]   topReg;
  logic [WORD-1:0]   prodNext;
  logic [WORD-1:0]   lower;
  logic [COEF_W-1:0] lowIdx;

  // element = index | block | zero pad, most significant first
  if (PAD_W > 0) begin : gPad
    assign alphaIn = {IDX_W'(blkIdx), inData, {PAD_W{1'b0}}};
  end else begin : gNoPad
    assign alphaIn = {IDX_W'(blkIdx), inData};
  end

  assign lowIdx = coefIdx - COEF_W'(1);
  assign lower  = (coefIdx == '0) ? '0 : acc[lowIdx];

  fsh_gf_mul_serial #(.POLY_LOW(BASE_POLY_LOW)) mul_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (st.capture | st.mulLast),
    .step     (st.mulStep),
    .mcand    (acc[coefIdx]),
    .bitIn    (alphaReg[~bitIdx]),
    .prodNext (prodNext)
  );

  // Coefficients are rewritten from the top down, so acc[j-1] still holds
  // its old value when coefficient j takes alpha*acc[j] + acc[j-1].
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < DEG; j++) acc[j] <= '0;
      alphaReg <= '0;
      topReg   <= '0;
    end else if (st.clear) begin
      for (int j = 0; j < DEG; j++) acc[j] <= '0;
    end else if (st.loadFirst) begin
      for (int j = 1; j < DEG; j++) acc[j] <= '0;
      acc[0] <= alphaIn;
    end else if (st.capture) begin
      alphaReg <= alphaIn;
      topReg   <= st.reduce ? acc[DEG-1] : '0;
    end else if (st.mulLast) begin
      acc[coefIdx] <= prodNext ^ lower;
    end else if (st.fold) begin
      acc[0]   <= acc[0] ^ topReg;
      acc[TAP] <= acc[TAP] ^ topReg;
    end
  end

  for (genvar g = 0; g < DEG; g++) begin : gFlat
    assign accFlat[g*WORD +: WORD] = acc[g];
  end

  AST_NO_TOP_BEFORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (st.capture && !st.reduce) |-> (acc[DEG-1] == '0)); // R4
  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    st.loadFirst |=> (acc[0] == $past(alphaIn))); // R3
  AST_CLEAR_AFTER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    st.clear |=> (accFlat == '0)); // R9
  AST_MUL_ONLY_WHEN_STEPPING: assert property (@(posedge clk) disable iff (!rst_n)
    st.mulLast |-> st.mulStep); // R6

endmodule

// File: rtl/fsh_accum.sv
module fsh_accum
  import fsh_pkg::*;
#(
  parameter int DEG        = 5,
  parameter int TAP        = 2,
  parameter int NUM_BLOCKS = 16,
  parameter int IDX_BYTES  = 1,
  parameter int BLK_BYTES  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inValid,
  input  logic [BLK_BYTES*8-1:0] inData,
  output logic                   inReady,
  output logic                   outValid,
  output logic [DEG*64-1:0]      outCoeffs
);

  localparam int CNT_W  = $clog2(NUM_BLOCKS + 1);
  localparam int COEF_W = $clog2(DEG);

  fshStrobe_t        st;
  logic [CNT_W-1:0]  blkIdx;
  logic [COEF_W-1:0] coefIdx;
  logic [5:0]        bitIdx;

  fsh_control #(
    .DEG(DEG), .NUM_BLOCKS(NUM_BLOCKS), .CNT_W(CNT_W), .COEF_W(COEF_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .st(st), .blkIdx(blkIdx), .coefIdx(coefIdx),
    .bitIdx(bitIdx)
  );

  fsh_datapath #(
    .DEG(DEG), .TAP(TAP), .IDX_BYTES(IDX_BYTES), .BLK_BYTES(BLK_BYTES),
    .CNT_W(CNT_W), .COEF_W(COEF_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .st(st), .blkIdx(blkIdx), .coefIdx(coefIdx),
    .bitIdx(bitIdx), .inData(inData), .accFlat(outCoeffs)
  );

endmodule

// File: tb/fsh_accum_tb_top.sv
module fsh_accum_tb_top;

  localparam int D    = 5;
  localparam int C    = 2;
  localparam int K    = 16;
  localparam int BUSY = 64 * D + 1;
  localparam int LAT  = 64 * D + 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            inValid = 1'b0;
  logic [31:0]     inData = '0;
  logic            inReady;
  logic            outValid;
  logic [D*64-1:0] outCoeffs;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] msg [K];

  always #2.5 clk = ~clk;

  fsh_accum #(.DEG(D), .TAP(C), .NUM_BLOCKS(K), .IDX_BYTES(1), .BLK_BYTES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outCoeffs(outCoeffs)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [D*64-1:0] act, input logic [D*64-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // LSB-first shift-and-add over GF(2^64), poly x^64+x^4+x^3+x+1
  function automatic logic [63:0] gfMul(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 64; i++) begin
      if (b[i]) r ^= a;
      a = {a[62:0], 1'b0} ^ (a[63] ? 64'h1B : 64'h0);
    end
    return r;
  endfunction

  function automatic logic [63:0] elemOf(input int n, input logic [31:0] d);
    return {n[7:0], d, 24'h0};
  endfunction

  function automatic logic [D*64-1:0] model();
    logic [63:0] a [D];
    logic [63:0] nw [D];
    logic [63:0] top, al;
    logic [D*64-1:0] res;
    for (int j = 0; j < D; j++) a[j] = '0;
    a[0] = elemOf(1, msg[0]);
    for (int n = 2; n <= K; n++) begin
      al  = elemOf(n, msg[n-1]);
      top = a[D-1];
      for (int j = 0; j < D; j++) nw[j] = gfMul(al, a[j]) ^ ((j > 0) ? a[j-1] : 64'h0);
      if (n >= D) begin
        nw[0] ^= top;
        nw[C] ^= top;
      end
      for (int j = 0; j < D; j++) a[j] = nw[j];
    end
    for (int j = 0; j < D; j++) res[j*64 +: 64] = a[j];
    return res;
  endfunction

  task automatic putBlock(input logic [31:0] d);
    inValid = 1'b1;
    inData  = d;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // sends msg[], optionally wiggling the input while stalled, checks all
  task automatic runMessage(input string name, input bit garbage, input string tags);
    logic [D*64-1:0] exp;
    int n;
    exp = model();
    @(negedge clk);
    for (int b = 0; b < K; b++) begin
      n = 0;
      while (!inReady && n < 2000) begin
        if (garbage) begin inValid = 1'b1; inData = ~msg[b] ^ 32'h5A5A0000; end
        n++;
        @(negedge clk);
      end
      if (b > 1)
        chk(n == BUSY, "R7", {name, " stall length"}, n, BUSY);
      putBlock(msg[b]);
    end
    n = 1;
    while (!outValid && n < 2000) begin
      if (garbage) begin inValid = 1'b1; inData = 32'hFFFF_0000; end
      @(negedge clk);
      n++;
    end
    inValid = 1'b0;
    chk(n == LAT, "R8", {name, " output latency"}, n, LAT);
    chk(outCoeffs == exp, tags, {name, " coefficients"}, outCoeffs, exp);
    @(negedge clk);
    chk(outValid == 1'b0, "R8", {name, " pulse width"}, outValid, 0);
    chk(outCoeffs == '0, "R9", {name, " cleared after output"}, outCoeffs, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(outValid == 1'b0, "R1", "reset outValid", outValid, 0);
    chk(inReady == 1'b1, "R1", "reset inReady", inReady, 1);
    chk(outCoeffs == '0, "R1", "reset outCoeffs", outCoeffs, 0);
  endtask

  task automatic testZeroData();  // element is the index alone
    for (int i = 0; i < K; i++) msg[i] = '0;
    runMessage("zero data", 1'b0, "R2 R3");
  endtask

  task automatic testPattern();
    for (int i = 0; i < K; i++) msg[i] = (i * 32'h0101_0101) ^ 32'h9E37_79B9;
    runMessage("pattern", 1'b0, "R4 R5 R6");
  endtask

  task automatic testOnes();
    for (int i = 0; i < K; i++) msg[i] = 32'hFFFF_FFFF;
    runMessage("all ones", 1'b0, "R5 R6");
  endtask

  task automatic testStallNoise();
    for (int i = 0; i < K; i++) msg[i] = 32'h1234_5678 + i * 32'h0F0F_1111;
    runMessage("stall noise", 1'b1, "R10");
  endtask

  task automatic testRepeat();
    for (int i = 0; i < K; i++) msg[i] = 32'hC001_D00D ^ (i << 7);
    runMessage("repeat first", 1'b0, "R9");
    runMessage("repeat second", 1'b0, "R9");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testZeroData();
    testPattern();
    testOnes();
    testStallNoise();
    testRepeat();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule